// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This block is one arithmetic lane for vector shift operations. It takes an integer element and a signed per-element shift count. A non-negative count shifts left and a negative count shifts right by its magnitude. Rounding on right shifts and saturation on left shifts can each be turned on or off. The element width is chosen per operation and can be 8, 16, 32 or 64 bits. Three operand modes are provided: signed to signed, unsigned to unsigned, and signed source with an unsigned saturating result.

Each operation presented with `valid_i` produces a registered result and a per-operation saturation bit one cycle later. Every saturating event also sets a sticky cumulative flag. This flag stays high until an explicit clear or a reset.

Top module: `srs_shift_lane`

## Requirements
- R1: `shift_i` is read as an 8-bit two's-complement count. A negative count shifts right by its magnitude and a non-negative count shifts left. `width_i` selects the element width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). `mode_i` selects the mode (0 = signed, 1 = unsigned, 2 = signed source with unsigned result, 3 = same as 1).
- R2: A right shift without rounding is arithmetic in signed mode and logical otherwise. A magnitude at or above the element width gives the sign fill in signed mode and 0 otherwise.
- R3: A right shift with rounding by n gives floor((x + 2^(n-1)) / 2^n), so halves round upward. In signed mode a magnitude at or above the width gives 0. In unsigned mode a magnitude of exactly the width gives the operand's top bit, and any larger magnitude gives 0.
- R4: A left shift by less than the width with saturation off gives the low width bits of the shifted operand.
- R5: A left shift with saturation on, where the value does not fit the element range, gives the saturation value and raises `sat_o`. The saturation value is the largest positive value (for a non-negative operand) or the most negative value (for a negative operand) in signed mode, and all ones at the element width otherwise.
- R6: A left shift by the width or more gives 0 when the operand is 0 or saturation is off. Otherwise it saturates as in R5.
- R7: In mode 2 with saturation on, a negative operand gives 0 and raises `sat_o` for any shift count. All other operands in mode 2 follow the unsigned rules.
- R8: `result_o`, `sat_o` and `valid_o` are registered and appear the cycle after `valid_i`. Result bits above the element width are 0. Operand bits above the element width are ignored. Without `valid_i`, `result_o` and `sat_o` hold their values.
- R9: `sat_flag_o` goes high after any operation that raises `sat_o` and stays high. It clears only on reset or on `flag_clr_i`. When a clear and a saturating operation arrive in the same cycle, the flag stays set.
- R10: After reset, `valid_o`, `result_o`, `sat_o` and `sat_flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 2 | Operand mode |
| width_i | input | 2 | Element width select |
| round_en_i | input | 1 | Enable rounding on right shifts |
| sat_en_i | input | 1 | Enable saturation |
| operand_i | input | 64 | Source element in the low width bits |
| shift_i | input | 8 | Signed shift count |
| flag_clr_i | input | 1 | Clear the sticky saturation flag |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Shifted element, zero above the width |
| sat_o | output | 1 | This operation saturated |
| sat_flag_o | output | 1 | Sticky cumulative saturation flag |

## Verification
A sticky-flag clear and a fresh saturating operation can land on the same clock edge. The bench provokes this on purpose by asserting `flag_clr_i` alongside a left shift that overflows, and also at random during the random phase. The bench keeps its own flag model, in which a set wins over a clear. It compares `sat_flag_o` against that model after every operation, so a clear that wins, or a clear that is ignored when alone, is reported.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    MODE_SS  = 2'd0,
    MODE_UU  = 2'd1,
    MODE_SU  = 2'd2,
    MODE_UU2 = 2'd3
  } srs_mode_e;
endpackage

// File: rtl/srs_prep.sv
module srs_prep #(
  parameter int DATA_W = 64,
  localparam int LVL_W = $clog2(DATA_W) + 1,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [1:0]        width_sel_i,
  input  logic              sign_ext_i,
  output logic [LVL_W-1:0]  elem_w_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              msb_o,
  output logic [EXT_W-1:0]  src_ext_o
);
  logic [DATA_W-1:0] top_bit;

  assign elem_w_o = LVL_W'(DATA_W >> (3 - int'(width_sel_i)));

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign mask_o[b] = (b < int'(elem_w_o));
  end

  assign top_bit = mask_o ^ (mask_o >> 1);
  assign msb_o   = |(operand_i & top_bit);

  always_comb begin
    if (sign_ext_i && msb_o) src_ext_o = {1'b1, operand_i | ~mask_o};
    else                     src_ext_o = {1'b0, operand_i & mask_o};
  end

  // R8
  always_comb begin
    mask_lsb_chk: assert (mask_o[0] && (top_bit != '0));
  end
endmodule

// File: rtl/srs_rshift.sv
module srs_rshift #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 8,
  localparam int EXT_W  = DATA_W + 1,
  localparam int CNT_W  = $clog2(EXT_W) + 1
) (
  input  logic [EXT_W-1:0]   src_ext_i,
  input  logic [SHAMT_W-1:0] mag_i,
  input  logic               round_i,
  output logic [DATA_W-1:0]  res_o
);
  logic [CNT_W-1:0]        nc;
  logic signed [EXT_W-1:0] src_s, part, plain;
  logic [EXT_W-1:0]        rnd;

  assign nc    = (int'(mag_i) >= EXT_W) ? CNT_W'(EXT_W) : CNT_W'(mag_i);
  assign src_s = $signed(src_ext_i);
  assign part  = src_s >>> (nc - CNT_W'(1));
  assign plain = src_s >>> nc;
  assign rnd   = (part >>> 1) + {{(EXT_W-1){1'b0}}, part[0]};
  assign res_o = round_i ? rnd[DATA_W-1:0] : plain[DATA_W-1:0];

  // R3
  always_comb begin
    if (round_i && int'(mag_i) >= EXT_W) rnd_far_zero_chk: assert (res_o == '0);
  end
endmodule

// File: rtl/srs_lshift.sv
module srs_lshift #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 8,
  localparam int EXT_W  = DATA_W + 1,
  localparam int LVL_W  = $clog2(DATA_W) + 1,
  localparam int WIDE_W = 2 * DATA_W + 1
) (
  input  logic [EXT_W-1:0]   src_ext_i,
  input  logic [SHAMT_W-2:0] amt_i,
  input  logic [LVL_W-1:0]   elem_w_i,
  input  logic [DATA_W-1:0]  mask_i,
  input  logic               signed_i,
  output logic [DATA_W-1:0]  val_o,
  output logic               ovf_o
);
  logic              big;
  logic [WIDE_W-1:0] wide, back;
  logic [DATA_W-1:0] trunc;
  logic              tmsb;

  assign big   = int'(amt_i) >= int'(elem_w_i);
  assign wide  = {{(WIDE_W-EXT_W){src_ext_i[EXT_W-1]}}, src_ext_i} << amt_i;
  assign trunc = wide[DATA_W-1:0] & mask_i;
  assign tmsb  = |(trunc & (mask_i ^ (mask_i >> 1)));

  always_comb begin
    if (signed_i && tmsb) back = {{(WIDE_W-DATA_W){1'b1}}, trunc | ~mask_i};
    else                  back = {{(WIDE_W-DATA_W){1'b0}}, trunc};
  end

  assign val_o = big ? '0 : trunc;
  assign ovf_o = big ? (src_ext_i != '0) : (wide != back);

  // R6
  always_comb begin
    if (src_ext_i == '0) lsh_zero_chk: assert (!ovf_o && val_o == '0);
  end
endmodule

// File: rtl/srs_sticky.sv
module srs_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> ($past(clr_i) && !$past(set_i)));
  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
endmodule

// File: rtl/srs_shift_lane.sv
module srs_shift_lane
  import srs_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 8,
  localparam int EXT_W  = DATA_W + 1,
  localparam int LVL_W  = $clog2(DATA_W) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  logic [1:0]         mode_i,
  input  logic [1:0]         width_i,
  input  logic               round_en_i,
  input  logic               sat_en_i,
  input  logic [DATA_W-1:0]  operand_i,
  input  logic [SHAMT_W-1:0] shift_i,
  input  logic               flag_clr_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               sat_o,
  output logic               sat_flag_o
);
  srs_mode_e         mode;
  logic              sign_src, neg_amt, su_block, msb;
  logic [SHAMT_W-1:0] mag;
  logic [LVL_W-1:0]  elem_w;
  logic [DATA_W-1:0] mask, rres, lval, sat_val, next_res;
  logic [EXT_W-1:0]  src_ext;
  logic              lovf, next_sat;

  assign mode     = srs_mode_e'(mode_i);
  assign sign_src = (mode == MODE_SS);
  assign neg_amt  = shift_i[SHAMT_W-1];
  assign mag      = -shift_i;

  srs_prep #(.DATA_W(DATA_W)) u_prep (
    .operand_i(operand_i), .width_sel_i(width_i), .sign_ext_i(sign_src),
    .elem_w_o(elem_w), .mask_o(mask), .msb_o(msb), .src_ext_o(src_ext)
  );

  srs_rshift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_rsh (
    .src_ext_i(src_ext), .mag_i(mag), .round_i(round_en_i), .res_o(rres)
  );

  srs_lshift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_lsh (
    .src_ext_i(src_ext), .amt_i(shift_i[SHAMT_W-2:0]), .elem_w_i(elem_w),
    .mask_i(mask), .signed_i(sign_src), .val_o(lval), .ovf_o(lovf)
  );

  assign su_block = (mode == MODE_SU) && sat_en_i && msb;

  always_comb begin
    if (!sign_src)  sat_val = mask;
    else if (msb)   sat_val = mask ^ (mask >> 1);
    else            sat_val = mask >> 1;
  end

  always_comb begin
    next_sat = 1'b0;
    if (su_block) begin
      next_res = '0;
      next_sat = 1'b1;
    end else if (neg_amt) begin
      next_res = rres & mask;
    end else if (lovf && sat_en_i) begin
      next_res = sat_val;
      next_sat = 1'b1;
    end else begin
      next_res = lval;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      sat_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= next_res;
        sat_o    <= next_sat;
      end
    end
  end

  srs_sticky u_flag (
    .clk(clk), .rst(rst), .set_i(valid_i && next_sat),
    .clr_i(flag_clr_i), .flag_o(sat_flag_o)
  );

  // R5
  sat_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && sat_o) |-> $past(sat_en_i));
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((result_o & ~$past(mask)) == '0));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(result_o) && $stable(sat_o));
endmodule

// File: tb/srs_shift_lane_bench.sv
module srs_shift_lane_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  width_i = '0;
  logic        round_en_i = 1'b0;
  logic        sat_en_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [7:0]  shift_i = '0;
  logic        flag_clr_i = 1'b0;
  logic        valid_o, sat_o, sat_flag_o;
  logic [63:0] result_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  bit  exp_flag = 1'b0;

  always #5 clk = ~clk;

  srs_shift_lane u_srs_shift_lane (
    .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i), .width_i(width_i),
    .round_en_i(round_en_i), .sat_en_i(sat_en_i), .operand_i(operand_i),
    .shift_i(shift_i), .flag_clr_i(flag_clr_i), .valid_o(valid_o),
    .result_o(result_o), .sat_o(sat_o), .sat_flag_o(sat_flag_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_op(input int mode, input int wsel, input bit rnd,
      input bit sat, input logic [63:0] op, input logic [7:0] sh,
      output logic [63:0] res, output bit sflag, output string tag);
    int W, s, n;
    bit sgn, negop, fits;
    logic [63:0] m;
    logic signed [199:0] one, v, q, full, lim;
    W     = 8 << wsel;
    m     = (W == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << W) - 64'd1);
    sgn   = (mode == 0);
    negop = op[W-1];
    one   = 200'sd1;
    v     = $signed({136'd0, op & m});
    if (sgn && negop) v = v - (one <<< W);
    s     = int'($signed(sh));
    sflag = 1'b0;
    if (mode == 2 && sat && negop) begin
      res = '0; sflag = 1'b1; tag = "R7";
    end else if (s < 0) begin
      n = -s;
      if (rnd) q = (v + (one <<< (n - 1))) >>> n;
      else     q = v >>> n;
      res = q[63:0] & m;
      tag = rnd ? "R3" : "R2";
    end else begin
      full = v <<< s;
      lim  = one <<< (W - 1);
      if (sgn) fits = (full >= -lim) && (full < lim);
      else     fits = (full < (one <<< W));
      if (fits || !sat) res = full[63:0] & m;
      else begin
        sflag = 1'b1;
        if (!sgn)      res = m;
        else if (negop) res = m ^ (m >> 1);
        else           res = m >> 1;
      end
      if (s >= W)  tag = "R6";
      else if (sat) tag = "R5";
      else          tag = "R4";
    end
  endfunction

  task automatic run_op(input int mode, input int wsel, input bit rnd, input bit sat,
      input logic [63:0] op, input logic [7:0] sh, input bit clr);
    logic [63:0] er;
    bit          es;
    string       tag;
    ref_op(mode, wsel, rnd, sat, op, sh, er, es, tag);
    @(negedge clk);
    valid_i = 1'b1; mode_i = 2'(mode); width_i = 2'(wsel);
    round_en_i = rnd; sat_en_i = sat; operand_i = op; shift_i = sh; flag_clr_i = clr;
    if (es) exp_flag = 1'b1;
    else if (clr) exp_flag = 1'b0;
    @(negedge clk);
    valid_i = 1'b0; flag_clr_i = 1'b0;
    check({tag, " result"}, result_o, er);
    check({tag, " sat_o"}, {63'd0, sat_o}, {63'd0, es});
    check("R8 valid_o", {63'd0, valid_o}, 64'd1);
    check("R9 sat_flag_o", {63'd0, sat_flag_o}, {63'd0, exp_flag});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] m, garb, held;
    logic [63:0] ops[6];
    int          shs[10];
    int          W;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10: state while and after reset
    check("R10 valid_o", {63'd0, valid_o}, 64'd0);
    check("R10 result_o", result_o, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 sat_o", {63'd0, sat_o}, 64'd0);
    check("R10 sat_flag_o", {63'd0, sat_flag_o}, 64'd0);

    // R1..R8 directed sweep over modes, widths, round and sat
    for (int wsel = 0; wsel < 4; wsel++) begin
      W = 8 << wsel;
      m = (W == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << W) - 64'd1);
      shs = '{-128, -W - 1, -W, -W + 1, -1, 0, 1, W - 1, W, 127};
      for (int mode = 0; mode < 4; mode++)
        for (int rs = 0; rs < 4; rs++)
          for (int si = 0; si < 10; si++) begin
            ops = '{64'd0, 64'd1, m >> 1, m ^ (m >> 1), m, {$urandom, $urandom}};
            for (int oi = 0; oi < 6; oi++) begin
              garb = {$urandom, $urandom} & ~m;
              run_op(mode, wsel, rs[0], rs[1], ops[oi] | garb, 8'(shs[si]), 1'b0);
            end
          end
    end

    // R9: clear together with a saturating operation keeps the flag set
    run_op(1, 0, 1'b0, 1'b1, 64'd1, 8'd127, 1'b0);
    run_op(1, 0, 1'b0, 1'b1, 64'd3, 8'd7, 1'b1);
    check("R9 set wins over clear", {63'd0, sat_flag_o}, 64'd1);
    // R9: clear alone drops the flag
    run_op(0, 1, 1'b0, 1'b1, 64'd5, 8'd1, 1'b1);
    check("R9 clear alone", {63'd0, sat_flag_o}, 64'd0);

    // R3: half rounds upward, exactly-width unsigned yields top bit
    run_op(0, 0, 1'b1, 1'b0, 64'h03, 8'hFF, 1'b0);
    check("R3 3>>1 rounded", result_o, 64'h02);
    run_op(1, 0, 1'b1, 1'b0, 64'h80, 8'hF8, 1'b0);
    check("R3 unsigned by -width", result_o, 64'h01);

    // R8: outputs hold with no strobe
    held = result_o;
    @(negedge clk);
    check("R8 valid_o low when idle", {63'd0, valid_o}, 64'd0);
    check("R8 result_o holds", result_o, held);

    // random phase, including random clears
    for (int k = 0; k < 2500; k++) begin
      run_op(int'($urandom % 4), int'($urandom % 4), 1'($urandom), 1'($urandom),
             {$urandom, $urandom}, 8'($urandom), ($urandom % 8) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule